// File: doc/BRIEF.md
# Asynchronous Serial Transmitter With Break

This block turns one character at a time into a non-return-to-zero serial stream on a single output line. It sends a low start bit, then the data bits with the least significant bit first, then a high stop bit. A mode input chooses between a short character (`DATA_W` bits) and a long character (`DATA_W+1` bits). Bit timing comes from `bit_tick`, a one-cycle enable pulse supplied from outside, and every bit on the line lasts exactly one tick period. Characters arrive through a valid/ready handshake into one holding register. On request, the block instead sends a break: the line is held low for a whole frame length, followed by one high mark bit.

Sequencing is done by a state machine. Its states are:
- `ST_IDLE`: line high, ready asserted.
- `ST_ARM_DATA` and `ST_ARM_BRK`: line high, waiting for the next tick so that the frame begins on a bit boundary.
- `ST_START`: the low start bit.
- `ST_DATA`: one data bit per tick period.
- `ST_STOP`: the high stop bit.
- `ST_BRK_LOW`: the low break period.
- `ST_BRK_MARK`: the trailing high mark bit.

Its transitions are:
- `ST_IDLE` to `ST_ARM_BRK` on a break request. This is checked first.
- `ST_IDLE` to `ST_ARM_DATA` on a completed handshake.
- Each arm state to `ST_START` or `ST_BRK_LOW` on a tick.
- `ST_START` to `ST_DATA` on a tick.
- `ST_DATA` to `ST_STOP` on the tick that ends the last data bit.
- `ST_BRK_LOW` to `ST_BRK_MARK` on the tick that ends the last low bit.
- `ST_STOP` and `ST_BRK_MARK` to `ST_IDLE` on a tick.

Top module: `serial_tx_break`

## Requirements
- R1: While no frame or break is in progress, `tx_line` is 1 and `tx_ready` equals the inverse of `brk_req`.
- R2: After a character is accepted (`tx_valid` and `tx_ready` high at a clock edge), the line stays 1 until the next tick. It is then 0 for exactly one tick period (the start bit).
- R3: After the start bit, the data bits appear one per tick period, starting with `tx_data[0]` and moving toward higher bit positions.
- R4: With `nine_bit_mode` = 1, nine bits `tx_data[8:0]` are sent. With `nine_bit_mode` = 0, eight bits `tx_data[7:0]` are sent and `tx_data[8]` has no effect.
- R5: After the last data bit, the line is 1 for exactly one tick period (the stop bit). The block then returns to idle.
- R6: A break request taken in idle holds the line 1 until the next tick. The line is then 0 for 10 tick periods in 8-bit mode, or 11 tick periods in 9-bit mode.
- R7: After the low period of a break, the line is 1 for one tick period (mark) before the block is idle again. Any following frame still waits one further high bit time before its start bit.
- R8: `tx_ready` is 0 from the accepting edge until the end of the frame. `tx_valid` and `tx_data` have no effect during that time, so a held request with new data does not alter the current frame.
- R9: When `brk_req` is 1 in idle, `tx_ready` is 0 and the break is taken instead of any offered character.
- R10: `nine_bit_mode` is captured at acceptance. Changing it later does not change the length of the current frame or break.
- R11: `frame_done` is 1 for exactly the single cycle in which the tick that ends a stop bit or a break mark bit is present. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-time boundary |
| nine_bit_mode | input | 1 | 1: nine data bits, 0: eight data bits |
| tx_valid | input | 1 | Character offered |
| tx_data | input | DATA_W+1 | Character; bit 0 is sent first |
| tx_ready | output | 1 | Character can be accepted this cycle |
| brk_req | input | 1 | Request a break frame |
| tx_line | output | 1 | Serial output, idles high |
| frame_done | output | 1 | Pulse at the end of a stop or mark bit |

## Verification
A wrong state or a wrong counter value shows at the ports within one tick period. A stuck arm state delays the start bit. An off-by-one in the bit counter moves the stop bit or the `frame_done` pulse by one tick period. A mis-latched mode changes the frame length by exactly one bit. A shift-register fault corrupts a data bit in the frame where it occurs, so comparing every character value against its expected bit pattern catches it within that frame. A wrong ready decode shows up as an accepted character that never appears, or as a frame disturbed by new data.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARM_DATA = 3'd1,
        ST_START    = 3'd2,
        ST_DATA     = 3'd3,
        ST_STOP     = 3'd4,
        ST_ARM_BRK  = 3'd5,
        ST_BRK_LOW  = 3'd6,
        ST_BRK_MARK = 3'd7
    } tx_state_e;

endpackage

// File: rtl/serial_tx_fsm.sv
module serial_tx_fsm
    import serial_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_tick,
    input  logic      take_data,
    input  logic      take_brk,
    input  logic      data_last,
    input  logic      brk_last,
    output tx_state_e state
);

    tx_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_brk)       state_nx = ST_ARM_BRK;
                else if (take_data) state_nx = ST_ARM_DATA;
            end
            ST_ARM_DATA: if (bit_tick) state_nx = ST_START;
            ST_START:    if (bit_tick) state_nx = ST_DATA;
            ST_DATA:     if (bit_tick && data_last) state_nx = ST_STOP;
            ST_STOP:     if (bit_tick) state_nx = ST_IDLE;
            ST_ARM_BRK:  if (bit_tick) state_nx = ST_BRK_LOW;
            ST_BRK_LOW:  if (bit_tick && brk_last) state_nx = ST_BRK_MARK;
            ST_BRK_MARK: if (bit_tick) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  tx_state_e         state,
    input  logic              load,
    input  logic              mode_in,
    input  logic [DATA_W:0]   data_in,
    output logic              bit_out,
    output logic              data_last,
    output logic              brk_last
);

    localparam int LONG_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(LONG_W + 2);
    localparam logic [CNT_W-1:0] LAST_SHORT     = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_LONG      = CNT_W'(LONG_W - 1);
    localparam logic [CNT_W-1:0] BRK_LAST_SHORT = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] BRK_LAST_LONG  = CNT_W'(LONG_W + 1);

    logic [DATA_W:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             long_q;

    // Mode and character are captured only at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '1;
            long_q <= 1'b0;
        end else if (load) begin
            long_q <= mode_in;
            shreg  <= mode_in ? data_in : {1'b0, data_in[DATA_W-1:0]};
        end else if (bit_tick && state == ST_DATA) begin
            shreg <= {1'b0, shreg[DATA_W:1]};
        end
    end

    // Bit counter shared by data bits and the break low period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (bit_tick) begin
            if (state == ST_START || state == ST_ARM_BRK)     cnt <= '0;
            else if (state == ST_DATA || state == ST_BRK_LOW) cnt <= cnt + 1'b1;
        end
    end

    assign bit_out   = shreg[0];
    assign data_last = (cnt == (long_q ? LAST_LONG : LAST_SHORT));
    assign brk_last  = (cnt == (long_q ? BRK_LAST_LONG : BRK_LAST_SHORT));

endmodule

// File: rtl/serial_tx_break.sv
module serial_tx_break
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            nine_bit_mode,
    input  logic            tx_valid,
    input  logic [DATA_W:0] tx_data,
    output logic            tx_ready,
    input  logic            brk_req,
    output logic            tx_line,
    output logic            frame_done
);

    tx_state_e state;
    logic      take_data;
    logic      take_brk;
    logic      data_last;
    logic      brk_last;
    logic      bit_out;
    logic      is_idle;

    assign is_idle   = (state == ST_IDLE);
    assign take_brk  = is_idle && brk_req;
    assign take_data = tx_valid && tx_ready;

    serial_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .take_data (take_data),
        .take_brk  (take_brk),
        .data_last (data_last),
        .brk_last  (brk_last),
        .state     (state)
    );

    serial_tx_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .state     (state),
        .load      (take_data || take_brk),
        .mode_in   (nine_bit_mode),
        .data_in   (tx_data),
        .bit_out   (bit_out),
        .data_last (data_last),
        .brk_last  (brk_last)
    );

    // Output decode
    always_comb begin
        tx_ready   = 1'b0;
        tx_line    = 1'b1;
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE:     tx_ready = !brk_req;
            ST_ARM_DATA: tx_line = 1'b1;
            ST_START:    tx_line = 1'b0;
            ST_DATA:     tx_line = bit_out;
            ST_STOP:     frame_done = bit_tick;
            ST_ARM_BRK:  tx_line = 1'b1;
            ST_BRK_LOW:  tx_line = 1'b0;
            ST_BRK_MARK: frame_done = bit_tick;
            default:     tx_line = 1'b1;
        endcase
    end

endmodule

// File: rtl/serial_tx_break_chk.sv
module serial_tx_break_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_valid,
    input logic brk_req,
    input logic tx_ready,
    input logic tx_line,
    input logic frame_done
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_line);

    // R8
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R9
    brk_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> !tx_ready);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (bit_tick && !tx_ready));

    // R3
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(tx_line));

endmodule

bind serial_tx_break serial_tx_break_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_valid   (tx_valid),
    .brk_req    (brk_req),
    .tx_ready   (tx_ready),
    .tx_line    (tx_line),
    .frame_done (frame_done)
);

// File: tb/serial_tx_break_test.sv
module serial_tx_break_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] div = 2'd0;
    logic       nine_bit_mode = 1'b0;
    logic       tx_valid = 1'b0;
    logic [8:0] tx_data = '0;
    logic       brk_req = 1'b0;
    logic       tx_ready;
    logic       tx_line;
    logic       frame_done;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div      <= div + 2'd1;
        bit_tick <= (div == 2'd3);
    end

    serial_tx_break uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .nine_bit_mode (nine_bit_mode),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .tx_ready      (tx_ready),
        .brk_req       (brk_req),
        .tx_line       (tx_line),
        .frame_done    (frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sample_tick;
        @(negedge clk);
        while (!bit_tick) @(negedge clk);
    endtask

    // Observe one frame after acceptance; d, m are the accepted values.
    task automatic capture(input logic [8:0] d, input logic m, input string req);
        int         nb = m ? 9 : 8;
        logic [10:0] got = '0;
        logic [10:0] exp = '0;
        bit          bad_ready = 0;
        bit          bad_done = 0;
        sample_tick;
        check(tx_line == 1'b1, "R2", "arm bit level", int'(tx_line), 1);
        for (int k = 0; k < nb; k++) exp[k+1] = d[k];
        exp[nb+1] = 1'b1;
        for (int i = 0; i < nb + 2; i++) begin
            sample_tick;
            got[i] = tx_line;
            if (tx_ready) bad_ready = 1;
            if (frame_done != (i == nb + 1)) bad_done = 1;
        end
        check(got == exp, req, "frame bits", int'(got), int'(exp));
        check(!bad_ready, "R8", "ready during frame", int'(bad_ready), 0);
        check(!bad_done, "R11", "done placement", int'(bad_done), 0);
        @(negedge clk);
        check(tx_ready && tx_line && !frame_done, "R1", "idle after frame",
              int'({tx_ready, tx_line, frame_done}), 3'b110);
    endtask

    task automatic offer(input logic [8:0] d, input logic m);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        nine_bit_mode = m;
        tx_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input logic [8:0] d, input logic m,
                             input bit flip, input string req);
        offer(d, m);
        tx_valid = 1'b0;
        if (flip) nine_bit_mode = ~m;
        capture(d, m, req);
        nine_bit_mode = m;
    endtask

    task automatic run_break(input logic m, input bit with_data, input bit flip);
        int nb = m ? 9 : 8;
        bit bad = 0;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        nine_bit_mode = m;
        brk_req = 1'b1;
        if (with_data) begin
            tx_valid = 1'b1;
            tx_data = 9'h0AA;
        end
        #1;
        check(!tx_ready, "R9", "ready with break request", int'(tx_ready), 0);
        @(posedge clk);
        #1;
        brk_req = 1'b0;
        tx_valid = 1'b0;
        if (flip) nine_bit_mode = ~m;
        sample_tick;
        check(tx_line == 1'b1, "R6", "break arm level", int'(tx_line), 1);
        for (int i = 0; i < nb + 2; i++) begin
            sample_tick;
            if (tx_line || frame_done || tx_ready) bad = 1;
        end
        check(!bad, "R6", "break low period", int'(bad), 0);
        sample_tick;
        check(tx_line && frame_done, "R7", "mark bit with done",
              int'({tx_line, frame_done}), 3);
        @(negedge clk);
        check(tx_ready && tx_line, "R7", "idle after break",
              int'({tx_ready, tx_line}), 3);
        nine_bit_mode = m;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tx_line && tx_ready && !frame_done, "R1", "reset state",
              int'({tx_line, tx_ready, frame_done}), 3'b110);
        rst_n = 1'b1;

        // R3 R4 R5: every 8-bit value, with bit 8 set to show it is ignored
        for (int v = 0; v < 256; v++)
            run_frame(9'h100 | 9'(v), 1'b0, 0, "R4");
        // R3 R5: every 9-bit value
        for (int v = 0; v < 512; v++)
            run_frame(9'(v), 1'b1, 0, "R3");

        // R10: mode changed after acceptance
        run_frame(9'h1C3, 1'b0, 1, "R10");
        run_frame(9'h13C, 1'b1, 1, "R10");

        // R8: request held with new data during a frame
        offer(9'h05A, 1'b0);
        tx_data = 9'h0A5;
        capture(9'h05A, 1'b0, "R8");
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
        capture(9'h0A5, 1'b0, "R8");

        // R6 R7: breaks in both modes, R10 mode flip, R9 priority
        run_break(1'b0, 0, 0);
        run_break(1'b1, 0, 0);
        run_break(1'b0, 0, 1);
        run_break(1'b1, 1, 1);

        // R7: frame right after a break keeps its arm bit
        run_break(1'b0, 0, 0);
        run_frame(9'h0F0, 1'b0, 0, "R2");

        // R1: ready tracks brk_req while idle
        @(negedge clk);
        brk_req = 1'b1;
        #1;
        check(!tx_ready && tx_line, "R1", "idle ready vs break",
              int'({tx_ready, tx_line}), 1);
        brk_req = 1'b0;
        #1;
        check(tx_ready && tx_line, "R1", "idle ready restored",
              int'({tx_ready, tx_line}), 3);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule